// File: doc/BRIEF.md
# Control and Status Register File for a Supervised Serial Controller

This block is the byte-wide register file that sits between a serial-slave front end and the rest of a UART controller with safety supervision. The front end drives a plain internal bus (address, write data, write strobe, read strobe) and gets read data back. The block holds the configuration fields and presents them as named outputs. It also folds live status inputs into a read-only word.

Several addresses have side effects. A write to the transmit byte launches a transmission. A read of the receive byte pops the receive queue. A write to the fault register acknowledges sticky faults one bit at a time. Two control bits act as self-clearing strobes: a watchdog service and a safe-state release. The transmitter, receive queue storage, CRC engine and watchdog timer sit outside this block. It only supplies their fields and strobes and collects their status.

Top module: `sercom_regfile`

## Requirements
- R1: After reset every stored field, every strobe output and every fault flag is 0, so the controller, watchdog and interrupts start disabled.
- R2: Address 0x00 is the mode register. Its bit 0 is enable, bit 1 is parity on, bit 2 is odd parity, bit 3 is loopback, bit 4 is CRC on and bit 5 is interrupt on. Bits 7:6 are not stored and read as 0.
- R3: The 16-bit baud divider output takes its low byte from address 0x01 and its high byte from address 0x02. Both read back as written.
- R4: A write to address 0x04 loads the transmit byte. `tx_start` is high for exactly the one cycle after the write. The address reads back the last byte written.
- R5: Address 0x03 is read-only status. Bit 0 is transmitter busy, bit 1 is receive data present (queue not empty), bit 2 is any fault flag set, and bit 3 is safe state. Bits 7:4 read 0, and writes to this address change nothing.
- R6: A read of address 0x05 while the receive queue is non-empty returns the queue head and raises `rx_pop` in the same cycle. While the queue is empty the read returns 0x00 and `rx_pop` stays low. Writes to this address change nothing.
- R7: Address 0x06 holds eight sticky fault flags. Each `fault_evt` bit sets its flag at the next edge. Writing 1 to a bit clears that flag, and writing 0 leaves it alone. A set and a clear of the same bit in the same cycle leave the flag set. `fault_active` is high whenever any flag is set.
- R8: Address 0x07 holds an 8-bit watchdog reload. At address 0x08, bit 0 is a stored watchdog enable. Writing 1 to bit 1 of address 0x08 raises `wdt_kick` for the one cycle after the write. Bit 1 and bits 7:2 of address 0x08 read 0.
- R9: At address 0x09, bit 0 is a stored safe-state enable and bits 7:4 are a stored critical-fault mask. Writing 1 to bit 1 raises `safe_clr` for the one cycle after the write. Bits 3:1 read 0.
- R10: Address 0x0A (interrupt mask) and address 0x0B (CRC settings) are full 8-bit read/write fields.
- R11: Writes to addresses 0x0C and above change no field and raise no strobe. Reads from those addresses return 0x00.
- R12: `bus_rdata` reflects the addressed register in the same cycle as `bus_re` and is 0x00 when `bus_re` is low. A write becomes visible on reads from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, same cycle as `bus_re` |
| cfg_enable | output | 1 | Controller enable |
| cfg_parity_en | output | 1 | Parity on |
| cfg_parity_odd | output | 1 | Odd parity select |
| cfg_loopback | output | 1 | Loopback select |
| cfg_crc_en | output | 1 | CRC on |
| cfg_irq_en | output | 1 | Interrupt on |
| baud_div | output | 16 | Baud divider |
| tx_data | output | 8 | Transmit byte |
| tx_start | output | 1 | One-cycle transmit launch |
| tx_busy | input | 1 | Transmitter busy status |
| rx_head | input | 8 | Byte at the receive queue head |
| rx_empty | input | 1 | Receive queue empty |
| rx_pop | output | 1 | Receive queue pop strobe |
| fault_evt | input | 8 | Fault event pulses, one per flag |
| fault_flags | output | 8 | Sticky fault flags |
| fault_active | output | 1 | Any fault flag set |
| wdt_reload | output | 8 | Watchdog reload value |
| wdt_enable | output | 1 | Watchdog enable |
| wdt_kick | output | 1 | One-cycle watchdog service strobe |
| safe_state | input | 1 | Safe state currently active |
| safe_en | output | 1 | Safe-state entry enable |
| safe_crit_mask | output | 4 | Critical-fault mask |
| safe_clr | output | 1 | One-cycle safe-state release strobe |
| irq_mask | output | 8 | Interrupt mask |
| crc_cfg | output | 8 | CRC settings |

## Verification
The bench drains the receive queue past empty. A design that pops on an empty queue, or that leaks the stale head byte onto the bus, shows up as a wrong `rx_pop` or a non-zero read. It races a fault event against a one-to-clear write on the same bit, which exposes a clear-over-set priority that would lose a fault. It writes the read-only and unmapped addresses with all ones, which catches a decoder that aliases high addresses onto low registers or lets status writes land. It also checks that the kick and release strobes and the transmit launch last exactly one cycle and never read back. A missing register stage, or a strobe held as a level, would show up there.

// File: rtl/sercom_reg_pkg.sv
`timescale 1ns/1ps
package sercom_reg_pkg;
  localparam int REG_DW   = 8;
  localparam int NUM_REGS = 12;

  // Register addresses (order is the bus contract)
  localparam int ADR_MODE  = 0;
  localparam int ADR_BDLO  = 1;
  localparam int ADR_BDHI  = 2;
  localparam int ADR_STAT  = 3;
  localparam int ADR_TXB   = 4;
  localparam int ADR_RXB   = 5;
  localparam int ADR_FLT   = 6;
  localparam int ADR_WDRL  = 7;
  localparam int ADR_WDCT  = 8;
  localparam int ADR_SAFE  = 9;
  localparam int ADR_IMSK  = 10;
  localparam int ADR_CRCC  = 11;

  localparam int MODE_W    = 6;
  localparam int BIT_KICK  = 1;
  localparam int BIT_SCLR  = 1;
  localparam int MASK_LSB  = 4;
  localparam int MASK_W    = 4;

  // Sticky flag update: clear requested bits, then set wins
  function automatic logic [REG_DW-1:0] sticky_next(
      input logic [REG_DW-1:0] cur,
      input logic [REG_DW-1:0] set_bits,
      input logic [REG_DW-1:0] clr_bits);
    return (cur & ~clr_bits) | set_bits;
  endfunction

  // Receive byte as seen on a read: zero when the queue is empty
  function automatic logic [REG_DW-1:0] rx_view(
      input logic [REG_DW-1:0] head,
      input logic              empty);
    return empty ? '0 : head;
  endfunction

  // Status word packing
  function automatic logic [REG_DW-1:0] status_word(
      input logic busy, input logic avail,
      input logic fault, input logic safe);
    return {{(REG_DW-4){1'b0}}, safe, fault, avail, busy};
  endfunction
endpackage

// File: rtl/sercom_reg_decode.sv
`timescale 1ns/1ps
module sercom_reg_decode #(
  parameter int ADDR_W = 8,
  parameter int NREG   = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              re,
  output logic [NREG-1:0]   wr_sel,
  output logic [NREG-1:0]   rd_sel
);
  for (genvar i = 0; i < NREG; i++) begin : g_sel
    logic match;
    assign match     = (addr == ADDR_W'(i));
    assign wr_sel[i] = we & match;
    assign rd_sel[i] = re & match;
  end
endmodule

// File: rtl/sercom_fault_sticky.sv
`timescale 1ns/1ps
module sercom_fault_sticky
  import sercom_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_DW-1:0] set_evt,
  input  logic [REG_DW-1:0] clr_mask,
  output logic [REG_DW-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= sticky_next(flags, set_evt, clr_mask);
  end

  // R7: without a clear, no flag ever drops
  p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask == '0) |=> ((flags & $past(flags)) == $past(flags)));

  // R7: an event always lands, even against a clear of the same bit
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt != '0) |=> ((flags & $past(set_evt)) == $past(set_evt)));
endmodule

// File: rtl/sercom_reg_rdmux.sv
`timescale 1ns/1ps
module sercom_reg_rdmux
  import sercom_reg_pkg::*;
#(
  parameter int NREG = 12
) (
  input  logic [NREG-1:0]             rd_sel,
  input  logic [NREG-1:0][REG_DW-1:0] words,
  output logic [REG_DW-1:0]           rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_sel[i]) rdata = rdata | words[i];
  end
endmodule

// File: rtl/sercom_regfile.sv
`timescale 1ns/1ps
module sercom_regfile
  import sercom_reg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [7:0]        bus_rdata,
  output logic              cfg_enable,
  output logic              cfg_parity_en,
  output logic              cfg_parity_odd,
  output logic              cfg_loopback,
  output logic              cfg_crc_en,
  output logic              cfg_irq_en,
  output logic [15:0]       baud_div,
  output logic [7:0]        tx_data,
  output logic              tx_start,
  input  logic              tx_busy,
  input  logic [7:0]        rx_head,
  input  logic              rx_empty,
  output logic              rx_pop,
  input  logic [7:0]        fault_evt,
  output logic [7:0]        fault_flags,
  output logic              fault_active,
  output logic [7:0]        wdt_reload,
  output logic              wdt_enable,
  output logic              wdt_kick,
  input  logic              safe_state,
  output logic              safe_en,
  output logic [3:0]        safe_crit_mask,
  output logic              safe_clr,
  output logic [7:0]        irq_mask,
  output logic [7:0]        crc_cfg
);
  localparam int NREG = NUM_REGS;

  logic [NREG-1:0] wsel, rsel;

  sercom_reg_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_decode (
    .addr  (bus_addr),
    .we    (bus_we),
    .re    (bus_re),
    .wr_sel(wsel),
    .rd_sel(rsel)
  );

  // Named access events for the checks below
  logic wr_txb, wr_kick, wr_sclr, rd_rxb;
  assign wr_txb  = wsel[ADR_TXB];
  assign wr_kick = wsel[ADR_WDCT] & bus_wdata[BIT_KICK];
  assign wr_sclr = wsel[ADR_SAFE] & bus_wdata[BIT_SCLR];
  assign rd_rxb  = rsel[ADR_RXB];

  logic [MODE_W-1:0] mode_q;
  logic [15:0]       baud_q;
  logic [7:0]        txb_q, wdrl_q, imsk_q, crcc_q;
  logic              wden_q, sen_q;
  logic [MASK_W-1:0] smask_q;
  logic              txs_q, kick_q, sclr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      baud_q  <= '0;
      txb_q   <= '0;
      wdrl_q  <= '0;
      imsk_q  <= '0;
      crcc_q  <= '0;
      wden_q  <= 1'b0;
      sen_q   <= 1'b0;
      smask_q <= '0;
    end else begin
      if (wsel[ADR_MODE]) mode_q       <= bus_wdata[MODE_W-1:0];
      if (wsel[ADR_BDLO]) baud_q[7:0]  <= bus_wdata;
      if (wsel[ADR_BDHI]) baud_q[15:8] <= bus_wdata;
      if (wr_txb)         txb_q        <= bus_wdata;
      if (wsel[ADR_WDRL]) wdrl_q       <= bus_wdata;
      if (wsel[ADR_WDCT]) wden_q       <= bus_wdata[0];
      if (wsel[ADR_SAFE]) begin
        sen_q   <= bus_wdata[0];
        smask_q <= bus_wdata[MASK_LSB +: MASK_W];
      end
      if (wsel[ADR_IMSK]) imsk_q       <= bus_wdata;
      if (wsel[ADR_CRCC]) crcc_q       <= bus_wdata;
    end
  end

  // Self-clearing strobes, one cycle after the triggering write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txs_q  <= 1'b0;
      kick_q <= 1'b0;
      sclr_q <= 1'b0;
    end else begin
      txs_q  <= wr_txb;
      kick_q <= wr_kick;
      sclr_q <= wr_sclr;
    end
  end

  logic [7:0] flt_clr;
  assign flt_clr = wsel[ADR_FLT] ? bus_wdata : 8'h00;

  sercom_fault_sticky u_fault (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (fault_evt),
    .clr_mask(flt_clr),
    .flags   (fault_flags)
  );

  assign fault_active = |fault_flags;
  assign rx_pop       = rd_rxb & ~rx_empty;

  // Read view of every address
  logic [NREG-1:0][7:0] rd_word;
  always_comb begin
    rd_word           = '0;
    rd_word[ADR_MODE] = {{(8-MODE_W){1'b0}}, mode_q};
    rd_word[ADR_BDLO] = baud_q[7:0];
    rd_word[ADR_BDHI] = baud_q[15:8];
    rd_word[ADR_STAT] = status_word(tx_busy, ~rx_empty, fault_active, safe_state);
    rd_word[ADR_TXB]  = txb_q;
    rd_word[ADR_RXB]  = rx_view(rx_head, rx_empty);
    rd_word[ADR_FLT]  = fault_flags;
    rd_word[ADR_WDRL] = wdrl_q;
    rd_word[ADR_WDCT] = {7'b0, wden_q};
    rd_word[ADR_SAFE] = {smask_q, 3'b000, sen_q};
    rd_word[ADR_IMSK] = imsk_q;
    rd_word[ADR_CRCC] = crcc_q;
  end

  sercom_reg_rdmux #(.NREG(NREG)) u_rdmux (
    .rd_sel(rsel),
    .words (rd_word),
    .rdata (bus_rdata)
  );

  assign cfg_enable     = mode_q[0];
  assign cfg_parity_en  = mode_q[1];
  assign cfg_parity_odd = mode_q[2];
  assign cfg_loopback   = mode_q[3];
  assign cfg_crc_en     = mode_q[4];
  assign cfg_irq_en     = mode_q[5];
  assign baud_div       = baud_q;
  assign tx_data        = txb_q;
  assign tx_start       = txs_q;
  assign wdt_reload     = wdrl_q;
  assign wdt_enable     = wden_q;
  assign wdt_kick       = kick_q;
  assign safe_en        = sen_q;
  assign safe_crit_mask = smask_q;
  assign safe_clr       = sclr_q;
  assign irq_mask       = imsk_q;
  assign crc_cfg        = crcc_q;

  // R4: a launch is always preceded by a transmit-byte write
  p_launch_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> $past(bus_we && bus_addr == ADDR_W'(ADR_TXB)));

  // R6: never pop an empty receive queue
  p_no_empty_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> !rx_empty);

  // R8: a service strobe comes only from a kick-bit write
  p_kick_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_kick |-> $past(bus_we && bus_addr == ADDR_W'(ADR_WDCT) && bus_wdata[BIT_KICK]));

  // R9: a release strobe comes only from a clear-bit write
  p_release_origin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    safe_clr |-> $past(bus_we && bus_addr == ADDR_W'(ADR_SAFE) && bus_wdata[BIT_SCLR]));

  // R11: unmapped writes leave the stored fields untouched
  p_unmapped_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr >= ADDR_W'(NREG)) |=>
      ($stable(baud_div) && $stable(irq_mask) && $stable(crc_cfg) && $stable(tx_data) && !tx_start));

  // R12: idle bus reads as zero
  p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |-> (bus_rdata == 8'h00));
endmodule

// File: tb/sercom_regfile_tb.sv
`timescale 1ns/1ps
module sercom_regfile_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0]  bus_addr = '0, bus_wdata = '0;
  logic        bus_we = 0, bus_re = 0;
  logic [7:0]  bus_rdata;
  logic        cfg_enable, cfg_parity_en, cfg_parity_odd, cfg_loopback, cfg_crc_en, cfg_irq_en;
  logic [15:0] baud_div;
  logic [7:0]  tx_data;
  logic        tx_start, rx_pop, fault_active, wdt_enable, wdt_kick, safe_en, safe_clr;
  logic        tx_busy = 0, rx_empty = 1, safe_state = 0;
  logic [7:0]  rx_head = '0, fault_evt = '0;
  logic [7:0]  fault_flags, wdt_reload, irq_mask, crc_cfg;
  logic [3:0]  safe_crit_mask;

  sercom_regfile u_dut (.*);

  int vecs = 0, errs = 0;

  // Behavioural model state
  logic [7:0]  rxq[$];
  logic [7:0]  m_mode, m_txb, m_flt, m_wdrl, m_imsk, m_crcc;
  logic [15:0] m_baud;
  logic        m_wden, m_sen, m_txs, m_kick, m_sclr;
  logic [3:0]  m_smask;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [7:0] a);
    if (a >= 8'd12) return "R11";
    case (a)
      8'd0: return "R2";  8'd1, 8'd2: return "R3"; 8'd3: return "R5";
      8'd4: return "R4";  8'd5: return "R6";       8'd6: return "R7";
      8'd7, 8'd8: return "R8"; 8'd9: return "R9";  default: return "R10";
    endcase
  endfunction

  function automatic logic [7:0] model_read(input logic [7:0] a);
    logic [7:0] v;
    v = 8'h00;
    case (a)
      8'd0:  v = m_mode & 8'h3F;
      8'd1:  v = m_baud[7:0];
      8'd2:  v = m_baud[15:8];
      8'd3:  v = {4'h0, safe_state, (m_flt != 0), (rxq.size() != 0), tx_busy};
      8'd4:  v = m_txb;
      8'd5:  v = (rxq.size() != 0) ? rxq[0] : 8'h00;
      8'd6:  v = m_flt;
      8'd7:  v = m_wdrl;
      8'd8:  v = {7'h0, m_wden};
      8'd9:  v = {m_smask, 3'b000, m_sen};
      8'd10: v = m_imsk;
      8'd11: v = m_crcc;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  task automatic check_outputs(input string req);
    chk(req, "mode bits", {26'h0, cfg_irq_en, cfg_crc_en, cfg_loopback, cfg_parity_odd, cfg_parity_en, cfg_enable}, {26'h0, m_mode[5:0]});
    chk(req, "baud_div", baud_div, m_baud);
    chk(req, "tx_data", tx_data, m_txb);
    chk(req, "tx_start", tx_start, m_txs);
    chk(req, "fault_flags", fault_flags, m_flt);
    chk(req, "fault_active", fault_active, (m_flt != 0));
    chk(req, "wdt_reload", wdt_reload, m_wdrl);
    chk(req, "wdt_enable", wdt_enable, m_wden);
    chk(req, "wdt_kick", wdt_kick, m_kick);
    chk(req, "safe_en", safe_en, m_sen);
    chk(req, "safe_crit_mask", safe_crit_mask, m_smask);
    chk(req, "safe_clr", safe_clr, m_sclr);
    chk(req, "irq_mask", irq_mask, m_imsk);
    chk(req, "crc_cfg", crc_cfg, m_crcc);
  endtask

  // One bus cycle; called at a falling edge
  task automatic step(input logic we, input logic re, input logic [7:0] a,
                      input logic [7:0] d, input logic [7:0] evt);
    logic [7:0] exp_rd;
    logic       exp_pop;
    string      t;
    bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d; fault_evt = evt;
    rx_empty = (rxq.size() == 0);
    rx_head  = (rxq.size() != 0) ? rxq[0] : 8'hA5;
    #1;
    t       = tag_of(a);
    exp_rd  = re ? model_read(a) : 8'h00;
    exp_pop = re && (a == 8'd5) && (rxq.size() != 0);
    chk(re ? t : "R12", "bus_rdata", bus_rdata, exp_rd);
    chk("R6", "rx_pop", rx_pop, exp_pop);
    @(posedge clk);
    m_txs  = we && (a == 8'd4);
    m_kick = we && (a == 8'd8) && d[1];
    m_sclr = we && (a == 8'd9) && d[1];
    m_flt  = (m_flt & ~((we && a == 8'd6) ? d : 8'h00)) | evt;
    if (we) case (a)
      8'd0:  m_mode = d & 8'h3F;
      8'd1:  m_baud[7:0] = d;
      8'd2:  m_baud[15:8] = d;
      8'd4:  m_txb = d;
      8'd7:  m_wdrl = d;
      8'd8:  m_wden = d[0];
      8'd9:  begin m_sen = d[0]; m_smask = d[7:4]; end
      8'd10: m_imsk = d;
      8'd11: m_crcc = d;
      default: ;
    endcase
    if (exp_pop) void'(rxq.pop_front());
    @(negedge clk);
    check_outputs(we ? t : (evt != 0 ? "R7" : "R12"));
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d); step(1, 0, a, d, 8'h00); endtask
  task automatic rd(input logic [7:0] a); step(0, 1, a, 8'h00, 8'h00); endtask
  task automatic idle(); step(0, 0, 8'h00, 8'h00, 8'h00); endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog run did not complete");
    summary();
    $finish;
  end

  initial begin
    m_mode = 0; m_txb = 0; m_flt = 0; m_wdrl = 0; m_imsk = 0; m_crcc = 0;
    m_baud = 0; m_wden = 0; m_sen = 0; m_txs = 0; m_kick = 0; m_sclr = 0; m_smask = 0;
    repeat (3) @(negedge clk);
    check_outputs("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs("R1");
    // R1: every address reads zero after reset
    for (int i = 0; i < 12; i++) rd(8'(i));

    // R2: mode register, upper bits dropped
    wr(8'd0, 8'hFF); rd(8'd0);
    wr(8'd0, 8'h15); rd(8'd0);
    // R3: baud halves
    wr(8'd1, 8'h34); wr(8'd2, 8'h12); rd(8'd1); rd(8'd2);
    // R4: launch pulse, back-to-back writes
    wr(8'd4, 8'h55); idle(); wr(8'd4, 8'hAA); wr(8'd4, 8'h0F); idle(); rd(8'd4);
    // R5: status fields, writes ignored
    tx_busy = 1; safe_state = 1; rxq.push_back(8'h3C);
    step(0, 0, 8'h00, 8'h00, 8'h10); rd(8'd3);
    wr(8'd3, 8'hFF); rd(8'd3);
    tx_busy = 0; safe_state = 0;
    // R6: drain past empty, writes ignored
    rxq.push_back(8'h7E); rxq.push_back(8'h01);
    wr(8'd5, 8'hFF);
    rd(8'd5); rd(8'd5); rd(8'd5); rd(8'd5); rd(8'd5);
    // R7: set, clear one bit, race set against clear
    step(0, 0, 8'h00, 8'h00, 8'h81); rd(8'd6);
    wr(8'd6, 8'h01); rd(8'd6);
    wr(8'd6, 8'h00); rd(8'd6);
    step(1, 0, 8'd6, 8'h80, 8'h80); rd(8'd6);
    wr(8'd6, 8'hFF); rd(8'd6); rd(8'd3);
    // R8: reload, enable, kick strobe
    wr(8'd7, 8'hC8); wr(8'd8, 8'h03); idle(); rd(8'd8);
    wr(8'd8, 8'h02); rd(8'd8);
    // R9: safe config and release strobe
    wr(8'd9, 8'hFF); idle(); rd(8'd9); wr(8'd9, 8'h02); rd(8'd9);
    // R10: full-width fields
    wr(8'd10, 8'h5A); wr(8'd11, 8'hC3); rd(8'd10); rd(8'd11);
    // R11: unmapped writes and reads
    for (int i = 12; i < 256; i += 17) begin wr(8'(i), 8'hFF); rd(8'(i)); end
    wr(8'hFF, 8'hFF); rd(8'hFF);

    // Mixed traffic against the model
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] a, d, e;
      logic       w, r;
      a = 8'($urandom_range(0, 15));
      if ($urandom_range(0, 40) == 0) a = 8'($urandom_range(12, 255));
      d = 8'($urandom);
      e = ($urandom_range(0, 7) == 0) ? 8'(1 << $urandom_range(0, 7)) : 8'h00;
      w = ($urandom_range(0, 2) == 0);
      r = !w && ($urandom_range(0, 1) == 0);
      tx_busy = 1'($urandom);
      safe_state = 1'($urandom);
      if (rxq.size() < 3 && $urandom_range(0, 3) == 0) rxq.push_back(8'($urandom));
      step(w, r, a, d, e);
    end

    summary();
    $finish;
  end
endmodule